// File: doc/BRIEF.md
# Low-Power Timer Event Status Unit

This block gathers the event flags of a small low-power timer into a single 32-bit read-only status word. It also raises one interrupt request line. Every flag is set by hardware from the events listed below, and stays set until software clears it.

- **Counter match (bit 0):** the counter reaches the compare value.
- **Counter match (bit 1):** the counter reaches the autoreload value.
- **Trigger (bit 2):** an external-trigger edge is accepted while the timer is idle.
- **Write completion (bits 3, 4):** a bus write to the compare register or to the autoreload register has completed.
- **Encoder direction (bits 5, 6):** the counting direction reverses while encoder mode is on.

Flags are cleared through a separate write-1-to-clear port. A 7-bit enable mask selects which flags drive the interrupt.

A two-state machine in each match detector (`MT_APART`, `MT_ON`) makes a match flag fire only on the first cycle of equality. The direction tracker is a three-state machine:

- `DIR_NONE`: no reference direction is held yet.
- `DIR_UP`: the last counting step went up.
- `DIR_DOWN`: the last counting step went down.

The tracker has these transitions:

- `DIR_NONE` moves to `DIR_UP` or `DIR_DOWN` on the first step, with no event.
- `DIR_UP` moves to `DIR_DOWN` on a down step and raises the up-to-down event.
- `DIR_DOWN` moves to `DIR_UP` on an up step and raises the down-to-up event.
- Any state returns to `DIR_NONE` while encoder mode is off.

Setting `HAS_ENC` to 0 removes the tracker, and bits 5 and 6 then read zero.

Top module: `lpt_evt_status`

## Requirements
- R1: While and right after reset is asserted (rst_n low), status and irq are all zeros.
- R2: Bit 0 of status is set the cycle after the first cycle in which cnt_val equals cmp_val. The previous cycle counts as unequal right after reset. No new set occurs while the equality persists.
- R3: Bit 1 of status follows the same first-equality rule as bit 0, with cnt_val compared against arr_val.
- R4: A trig_edge pulse sets bit 2 the next cycle only if tmr_running is low in that cycle; with tmr_running high it has no effect.
- R5: A cmp_wr_done pulse sets bit 3 and an arr_wr_done pulse sets bit 4, one cycle later.
- R6: When HAS_ENC is 1, the direction is judged on cycles with cnt_step high and enc_en high (dir_down=1 means down).
  - A step down after a step up sets bit 6.
  - A step up after a step down sets bit 5.
  - No flag is raised at the first step after reset, or after enc_en has been low.
- R7: When clr_wr is high, each flag whose bit in clr_data is 1 is cleared the next cycle. Bits of clr_data that are 0 leave their flag unchanged. Status bits 31 to 7 always read zero.
- R8: If a set event and a clear of the same flag fall in one cycle, the flag ends up set.
- R9: irq is a register. After each edge it equals the OR of (status bits after that edge AND irq_en sampled at that edge).
- R10: When HAS_ENC is 0, status bits 5 and 6 always read zero, whatever the direction inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_val | input | CNT_W | Current counter value |
| arr_val | input | CNT_W | Autoreload value |
| cmp_val | input | CNT_W | Compare value |
| enc_en | input | 1 | Encoder mode enabled |
| cnt_step | input | 1 | Counting step taken this cycle |
| dir_down | input | 1 | Direction of the step, 1 = down |
| trig_edge | input | 1 | Valid external-trigger edge pulse |
| tmr_running | input | 1 | Timer already started |
| cmp_wr_done | input | 1 | Compare register write completed |
| arr_wr_done | input | 1 | Autoreload register write completed |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_data | input | 32 | Clear mask, 1 clears the matching flag |
| irq_en | input | 7 | Per-flag interrupt enables |
| status | output | 32 | Status word |
| irq | output | 1 | Registered interrupt request |

## Verification
The set path and the clear path are the two functions that can meet in one cycle on the same flag. A clear write carrying all ones is issued together with a completion pulse, and the flag must survive. A random phase then overlaps every event source with random clear masks and enables. A behavioural model in the bench recomputes each flag as (old AND NOT clear) OR set, and the outputs are compared against it on every clock.

// File: rtl/lpt_evt_pkg.sv
package lpt_evt_pkg;
    localparam int FLAG_N = 7;
    localparam int STAT_W = 32;
    localparam int F_CMPM = 0;
    localparam int F_ARRM = 1;
    localparam int F_TRIG = 2;
    localparam int F_CMPW = 3;
    localparam int F_ARRW = 4;
    localparam int F_UP   = 5;
    localparam int F_DOWN = 6;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_state_e;

    typedef enum logic {
        MT_APART = 1'b0,
        MT_ON    = 1'b1
    } match_state_e;
endpackage

// File: rtl/lpt_evt_match.sv
module lpt_evt_match
    import lpt_evt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] value,
    input  logic [W-1:0] target,
    output logic         hit
);
    match_state_e st_q, st_d;
    logic         eq_now;

    assign eq_now = (value == target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MT_APART;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = eq_now ? MT_ON : MT_APART;
    end

    always_comb begin
        hit = 1'b0;
        unique case (st_q)
            MT_APART: hit = eq_now;
            MT_ON:    hit = 1'b0;
            default:  hit = 1'b0;
        endcase
    end

    // R2 / R3: a match event never repeats on consecutive cycles
    a_r2_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/lpt_evt_dir.sv
module lpt_evt_dir
    import lpt_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enc_en,
    input  logic step,
    input  logic dir_down,
    output logic up_evt,
    output logic dn_evt
);
    dir_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DIR_NONE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (!enc_en) begin
            st_d = DIR_NONE;
        end else if (step) begin
            unique case (st_q)
                DIR_NONE: st_d = dir_down ? DIR_DOWN : DIR_UP;
                DIR_UP:   st_d = dir_down ? DIR_DOWN : DIR_UP;
                DIR_DOWN: st_d = dir_down ? DIR_DOWN : DIR_UP;
                default:  st_d = DIR_NONE;
            endcase
        end
    end

    always_comb begin
        up_evt = 1'b0;
        dn_evt = 1'b0;
        if (enc_en && step) begin
            unique case (st_q)
                DIR_NONE: ;
                DIR_UP:   dn_evt = dir_down;
                DIR_DOWN: up_evt = !dir_down;
                default:  ;
            endcase
        end
    end

    // R6: events only on an enabled counting step
    a_r6_step_only: assert property (@(posedge clk) disable iff (!rst_n)
        (up_evt || dn_evt) |-> (step && enc_en));
    // R6: first step after enabling encoder mode is quiet
    a_r6_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enc_en) |-> !(up_evt || dn_evt));
    // R6: never both directions at once
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({up_evt, dn_evt}));
endmodule

// File: rtl/lpt_evt_flags.sv
module lpt_evt_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flags_q,
    output logic [N-1:0] flags_d
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            if (set_evt[i])      flags_d[i] = 1'b1;
            else if (clr_req[i]) flags_d[i] = 1'b0;
            else                 flags_d[i] = flags_q[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_q[i] <= 1'b0;
            else        flags_q[i] <= flags_d[i];
        end

        // R8: a set event always lands, even against a clear
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> flags_q[i]);
        // R7: an uncontested clear takes effect
        a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[i] && !set_evt[i]) |=> !flags_q[i]);
        // R7: with neither set nor clear, the flag holds
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_req[i] && !set_evt[i]) |=> (flags_q[i] == $past(flags_q[i])));
    end
endmodule

// File: rtl/lpt_evt_status.sv
module lpt_evt_status
    import lpt_evt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit HAS_ENC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [CNT_W-1:0]  arr_val,
    input  logic [CNT_W-1:0]  cmp_val,
    input  logic              enc_en,
    input  logic              cnt_step,
    input  logic              dir_down,
    input  logic              trig_edge,
    input  logic              tmr_running,
    input  logic              cmp_wr_done,
    input  logic              arr_wr_done,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_data,
    input  logic [FLAG_N-1:0] irq_en,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    localparam int RSV_W = STAT_W - FLAG_N;

    logic [FLAG_N-1:0] set_evt;
    logic [FLAG_N-1:0] clr_req;
    logic [FLAG_N-1:0] flags_q;
    logic [FLAG_N-1:0] flags_d;
    logic              cmp_hit;
    logic              arr_hit;
    logic              up_evt;
    logic              dn_evt;
    logic              irq_q;
    logic              unused_clr_hi;

    assign unused_clr_hi = ^clr_data[STAT_W-1:FLAG_N];

    lpt_evt_match #(.W(CNT_W)) u_cmp_match (
        .clk(clk), .rst_n(rst_n), .value(cnt_val), .target(cmp_val), .hit(cmp_hit)
    );

    lpt_evt_match #(.W(CNT_W)) u_arr_match (
        .clk(clk), .rst_n(rst_n), .value(cnt_val), .target(arr_val), .hit(arr_hit)
    );

    if (HAS_ENC) begin : g_enc
        lpt_evt_dir u_dir (
            .clk(clk), .rst_n(rst_n), .enc_en(enc_en), .step(cnt_step),
            .dir_down(dir_down), .up_evt(up_evt), .dn_evt(dn_evt)
        );
    end else begin : g_noenc
        logic unused_dir;
        assign unused_dir = enc_en ^ cnt_step ^ dir_down;
        assign up_evt = 1'b0;
        assign dn_evt = 1'b0;
    end

    always_comb begin
        set_evt         = '0;
        set_evt[F_CMPM] = cmp_hit;
        set_evt[F_ARRM] = arr_hit;
        set_evt[F_TRIG] = trig_edge && !tmr_running;
        set_evt[F_CMPW] = cmp_wr_done;
        set_evt[F_ARRW] = arr_wr_done;
        set_evt[F_UP]   = up_evt;
        set_evt[F_DOWN] = dn_evt;
        clr_req         = clr_wr ? clr_data[FLAG_N-1:0] : '0;
    end

    lpt_evt_flags #(.N(FLAG_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_req(clr_req),
        .flags_q(flags_q), .flags_d(flags_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flags_d & irq_en);
    end

    assign status = {{RSV_W{1'b0}}, flags_q};
    assign irq    = irq_q;

    // R7: reserved upper bits read zero
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[STAT_W-1:FLAG_N] == '0);
    // R9: interrupt tracks visible status and the enables sampled at the edge
    a_r9_irq_track: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(status[FLAG_N-1:0] & $past(irq_en)));

    if (!HAS_ENC) begin : g_chk_noenc
        // R10: direction flags absent without encoder support
        a_r10_dir_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
            status[F_DOWN:F_UP] == 2'b00);
    end
endmodule

// File: tb/lpt_evt_status_bench.sv
module lpt_evt_status_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_val = '0, arr_val = 16'd9, cmp_val = 16'd5;
    logic         enc_en = 0, cnt_step = 0, dir_down = 0;
    logic         trig_edge = 0, tmr_running = 0;
    logic         cmp_wr_done = 0, arr_wr_done = 0;
    logic         clr_wr = 0;
    logic [31:0]  clr_data = '0;
    logic [6:0]   irq_en = '0;
    logic [31:0]  status, status_ne;
    logic         irq, irq_ne;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [6:0] m_stat = '0;
    logic       m_irq = 0;
    bit         m_ceq = 0, m_aeq = 0;
    int         m_dir = -1;

    always #10 clk = ~clk;

    lpt_evt_status #(.CNT_W(W), .HAS_ENC(1'b1)) u_lpt_evt_status (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .arr_val(arr_val), .cmp_val(cmp_val),
        .enc_en(enc_en), .cnt_step(cnt_step), .dir_down(dir_down),
        .trig_edge(trig_edge), .tmr_running(tmr_running),
        .cmp_wr_done(cmp_wr_done), .arr_wr_done(arr_wr_done),
        .clr_wr(clr_wr), .clr_data(clr_data), .irq_en(irq_en),
        .status(status), .irq(irq)
    );

    lpt_evt_status #(.CNT_W(W), .HAS_ENC(1'b0)) u_noenc (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .arr_val(arr_val), .cmp_val(cmp_val),
        .enc_en(enc_en), .cnt_step(cnt_step), .dir_down(dir_down),
        .trig_edge(trig_edge), .tmr_running(tmr_running),
        .cmp_wr_done(cmp_wr_done), .arr_wr_done(arr_wr_done),
        .clr_wr(clr_wr), .clr_data(clr_data), .irq_en(irq_en),
        .status(status_ne), .irq(irq_ne)
    );

    function automatic string req_of_bit(int b);
        case (b)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R5";
            5: return "R6";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [31:0] exp_s;
        logic [31:0] diff;
        int first;
        exp_s = {25'b0, m_stat};
        diff  = status ^ exp_s;
        first = -1;
        for (int b = 31; b >= 0; b--) if (diff[b]) first = b;
        check(first < 0, (first < 0) ? "R7" : req_of_bit(first), "status", status, exp_s);
        check(irq == m_irq, "R9", "irq", {31'b0, irq}, {31'b0, m_irq});
        check(status_ne == (exp_s & 32'h1F), "R10", "noenc status", status_ne, exp_s & 32'h1F);
    endtask

    task automatic step_cycle();
        logic [6:0] set;
        logic [6:0] clr;
        bit ceq, aeq;
        set = '0;
        ceq = (cnt_val == cmp_val);
        aeq = (cnt_val == arr_val);
        if (ceq && !m_ceq) set[0] = 1'b1;
        if (aeq && !m_aeq) set[1] = 1'b1;
        m_ceq = ceq;
        m_aeq = aeq;
        if (trig_edge && !tmr_running) set[2] = 1'b1;
        if (cmp_wr_done) set[3] = 1'b1;
        if (arr_wr_done) set[4] = 1'b1;
        if (!enc_en) m_dir = -1;
        else if (cnt_step) begin
            if (m_dir == 0 && dir_down)  set[6] = 1'b1;
            if (m_dir == 1 && !dir_down) set[5] = 1'b1;
            m_dir = dir_down ? 1 : 0;
        end
        clr = clr_wr ? clr_data[6:0] : '0;
        m_stat = (m_stat & ~clr) | set;
        m_irq = |(m_stat & irq_en);
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle();
        cnt_step = 0; trig_edge = 0; cmp_wr_done = 0; arr_wr_done = 0;
        clr_wr = 0; clr_data = '0;
    endtask

    task automatic clear_all();
        clr_wr = 1; clr_data = 32'hFFFF_FFFF;
        step_cycle();
        idle();
    endtask

    task automatic enc_step(bit dn);
        cnt_step = 1; dir_down = dn;
        step_cycle();
        cnt_step = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        repeat (3) @(posedge clk);
        #1;
        check(status == 0, "R1", "status in reset", status, 0);
        check(irq == 0, "R1", "irq in reset", {31'b0, irq}, 0);
        rst_n = 1;
        cnt_val = 16'd1;
        step_cycle();

        // R2 / R3: counter sweep, hold at compare value
        for (int v = 2; v <= 9; v++) begin
            cnt_val = W'(v);
            step_cycle();
            if (v == 5) begin
                repeat (3) step_cycle();
                check(status[0] == 1'b1, "R2", "cmp flag after hold", status, 1);
                clear_all();
                repeat (2) step_cycle();
                check(status[0] == 1'b0, "R2", "no re-raise while equal", status, 0);
            end
        end
        check(status[1] == 1'b1, "R3", "arr flag", status, 2);

        // R7: zero bits of the clear mask leave flags alone
        clr_wr = 1; clr_data = 32'hFFFF_FF81;
        step_cycle(); idle();
        check(status[1] == 1'b1, "R7", "arr flag kept under 0 clear bit", status, 2);
        clear_all();

        // R4: trigger suppressed while running
        tmr_running = 1; trig_edge = 1;
        step_cycle(); idle();
        check(status[2] == 1'b0, "R4", "trigger ignored while running", status, 0);
        tmr_running = 0; trig_edge = 1;
        step_cycle(); idle();
        check(status[2] == 1'b1, "R4", "trigger accepted while idle", status, 4);

        // R5: write completions
        cmp_wr_done = 1; step_cycle(); idle();
        arr_wr_done = 1; step_cycle(); idle();
        check(status[4:3] == 2'b11, "R5", "write done flags", status, 32'h18);

        // R8: set and clear in the same cycle
        clear_all();
        cmp_wr_done = 1; clr_wr = 1; clr_data = 32'hFFFF_FFFF;
        step_cycle(); idle();
        check(status[3] == 1'b1, "R8", "set beats clear", status, 8);

        // R9: interrupt enables
        irq_en = 7'b0000001; step_cycle();
        check(irq == 1'b0, "R9", "masked flag gives no irq", {31'b0, irq}, 0);
        irq_en = 7'b0001000; step_cycle();
        check(irq == 1'b1, "R9", "enabled flag drives irq", {31'b0, irq}, 1);
        clear_all();

        // R6: encoder direction reversals
        enc_en = 1;
        enc_step(1);
        check(status[6:5] == 2'b00, "R6", "first step quiet", status, 0);
        enc_step(1);
        enc_step(0);
        check(status[5] == 1'b1, "R6", "down to up", status, 32'h20);
        enc_step(1);
        check(status[6] == 1'b1, "R6", "up to down", status, 32'h60);
        clear_all();
        enc_en = 0; step_cycle();
        enc_en = 1; enc_step(0);
        check(status[6:5] == 2'b00, "R6", "quiet after re-enable", status, 0);
        enc_step(1);
        check(status_ne[6:5] == 2'b00, "R10", "noenc dir bits", status_ne, 0);

        // mixed random phase
        for (int k = 0; k < 600; k++) begin
            cnt_val     = W'($urandom_range(0, 7));
            cmp_val     = W'($urandom_range(0, 7));
            arr_val     = W'($urandom_range(0, 7));
            enc_en      = ($urandom_range(0, 15) != 0);
            cnt_step    = $urandom_range(0, 1);
            dir_down    = $urandom_range(0, 1);
            trig_edge   = ($urandom_range(0, 3) == 0);
            tmr_running = $urandom_range(0, 1);
            cmp_wr_done = ($urandom_range(0, 5) == 0);
            arr_wr_done = ($urandom_range(0, 5) == 0);
            clr_wr      = ($urandom_range(0, 2) == 0);
            clr_data    = $urandom;
            irq_en      = 7'($urandom);
            step_cycle();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule